// File: doc/BRIEF.md
# Fluorescent Display Scan Timing Controller

This block produces the digit-scan timing for a multiplexed vacuum fluorescent display. Software programs a slot length, a frame size and a frame-end blanking length through a small synchronous register port. After a start command the block lights one digit-enable output at a time, steps through 16 or 32 slots per frame, optionally idles for a few slot times after the final slot, and then starts the next frame at digit 0.

Each slot is timed by a prescaled tick: the input clock is divided by 32 or 128, and the programmed 8-bit value N gives N+1 ticks per slot. An interrupt pulse follows one of two rules, picked by the blanking code. The block can also switch off the digits during the last tick of each slot, invert a group of four digit outputs, and drive a two-level gradation signal whose set and clear points trade places under a swap bit.

Top module: `vfd_scan_timer`

## Requirements
- R1: After reset every register reads 0x00, every digit output is 0 and `irq` and `gradOut` are 0.
- R2: Address 0 holds the mode: bit0 auto-scan enable, bit1 start, bits3:2 blanking code, bit4 32-slot frame, bit5 gradation enable, bit6 slow prescaler; bit7 ignores writes and reads 0. Address 1 holds output control: bit0 group invert, bit2 group off-exempt, bit5 off-phase enable, bit7 gradation swap; its other bits read 0. Address 2 holds the 8-bit slot value N, any value accepted. Address 3 reads 0.
- R3: While the auto-scan bit is 0 no scan runs and every digit output stays at its inactive level, even if the start bit is written to 1.
- R4: A write to address 0 that takes the start bit from 0 to 1 with auto-scan set starts a frame: digit k (output bit k, active high, one-hot) is driven from clock edge k*S to edge (k+1)*S after the write edge, with S = (N+1)*D. Clearing the start bit or the auto-scan bit stops the scan and darkens all digits.
- R5: The prescale divisor D is 32 when mode bit6 is 0 and 128 when it is 1.
- R6: A frame has 16 slots (digits 0..15) when mode bit4 is 0 and 32 slots (digits 0..31) when it is 1; with gradation enabled the frame has 16 slots regardless of bit4.
- R7: Blanking code c (0..3) inserts c slot times with no digit driven after the last slot of each frame, after which digit 0 starts again.
- R8: With code 0, `irq` pulses for one cycle at the start of every slot, including the first slot after start. With a nonzero code, `irq` pulses once per frame, at the end of the last slot, and not at start.
- R9: When the group invert bit is 1, digit outputs 7..4 are inverted: their inactive level is 1, including when idle.
- R10: With the off-phase bit set, a digit is inactive during the last D cycles of its slot; with the off-exempt bit also set, digits 7..4 stay active through that phase.
- R11: With gradation enabled during a scan, `gradOut` is 1 in a slot's first N*D cycles and 0 in its last D cycles when the swap bit is 0, and the reverse when the swap bit is 1; with gradation disabled it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for `addr` |
| digitOut | output | 32 | Per-slot digit enables |
| gradOut | output | 1 | Gradation output |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench sweeps slot values 0, 1 and 3, both divisors and all four blanking codes, checking the lit digit in the middle of every slot; an off-by-one in the slot reload would drift the digit boundaries and land later samples on the wrong digit. It counts interrupt pulses over exact frame windows, so a design that fires at start under a nonzero code, or misses the wrap pulse under code 0, gives the wrong count. It probes the frame end, where a wrong slot limit under gradation would light digit 16, and the off phase, where a dropped exemption or inverted gradation swap shows up as a wrong level in the last tick of a slot.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

  typedef struct packed {
    logic restart;
    logic reload;
    logic stepIdx;
    logic wrapIdx;
    logic irqFire;
  } scanStrb_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_BLANK = 2'd2
  } scanState_t;

endpackage

// File: rtl/vfd_scan_regs.sv
module vfd_scan_regs #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       addr,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  output logic             autoEn,
  output logic             startBit,
  output logic [1:0]       scanCode,
  output logic             wide32,
  output logic             gradEn,
  output logic             slowClk,
  output logic             invGrp,
  output logic             grpNoOff,
  output logic             offGen,
  output logic             swapGrad,
  output logic [PER_W-1:0] period,
  output logic             startRise
);

  logic modeWr;
  assign modeWr = wrEn && (addr == 2'd0);

  // start edge: new value has auto and start, old start was clear
  assign startRise = modeWr && wrData[0] && wrData[1] && !startBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      autoEn <= 1'b0; startBit <= 1'b0; scanCode <= 2'd0;
      wide32 <= 1'b0; gradEn <= 1'b0; slowClk <= 1'b0;
      invGrp <= 1'b0; grpNoOff <= 1'b0; offGen <= 1'b0; swapGrad <= 1'b0;
      period <= '0;
    end else if (wrEn) begin
      case (addr)
        2'd0: begin
          autoEn   <= wrData[0];
          startBit <= wrData[1];
          scanCode <= wrData[3:2];
          wide32   <= wrData[4];
          gradEn   <= wrData[5];
          slowClk  <= wrData[6];
        end
        2'd1: begin
          invGrp   <= wrData[0];
          grpNoOff <= wrData[2];
          offGen   <= wrData[5];
          swapGrad <= wrData[7];
        end
        2'd2: period <= wrData[PER_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdData = {1'b0, slowClk, gradEn, wide32, scanCode, startBit, autoEn};
      2'd1:    rdData = {swapGrad, 1'b0, offGen, 2'b00, grpNoOff, 1'b0, invGrp};
      2'd2:    rdData = 8'(period);
      default: rdData = 8'h00;
    endcase
  end

endmodule

// File: rtl/vfd_scan_ctrl.sv
module vfd_scan_ctrl
  import vfd_scan_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       startRise,
  input  logic [1:0] scanCode,
  input  logic       slotEnd,
  input  logic       lastSlot,
  output scanStrb_t  strb,
  output logic       scanOn,
  output logic       runOn
);

  scanState_t state;
  logic [1:0] blankRem;
  logic       codeZero;

  assign codeZero = (scanCode == 2'd0);
  assign scanOn   = enable && (state == ST_SCAN);
  assign runOn    = enable && (state != ST_IDLE);

  always_comb begin
    strb = '0;
    if (startRise) begin
      strb.restart = 1'b1;
      strb.irqFire = codeZero;
    end else if (runOn && slotEnd) begin
      strb.reload = 1'b1;
      if (state == ST_SCAN) begin
        if (lastSlot) begin
          strb.wrapIdx = codeZero;
          strb.irqFire = 1'b1;
        end else begin
          strb.stepIdx = 1'b1;
          strb.irqFire = codeZero;
        end
      end else if (blankRem == 2'd1) begin
        strb.wrapIdx = 1'b1;
        strb.irqFire = codeZero;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      blankRem <= 2'd0;
    end else if (startRise) begin
      state    <= ST_SCAN;
      blankRem <= 2'd0;
    end else if (!enable) begin
      state <= ST_IDLE;
    end else if (runOn && slotEnd) begin
      if (state == ST_SCAN && lastSlot && !codeZero) begin
        state    <= ST_BLANK;
        blankRem <= scanCode;
      end else if (state == ST_BLANK) begin
        if (blankRem <= 2'd1) state <= ST_SCAN;
        else blankRem <= blankRem - 2'd1;
      end
    end
  end

endmodule

// File: rtl/vfd_scan_dp.sv
module vfd_scan_dp
  import vfd_scan_pkg::*;
#(
  parameter int PER_W     = 8,
  parameter int NUM_SLOTS = 32,
  parameter int DIV_FAST  = 32,
  parameter int DIV_SLOW  = 128,
  parameter int GRP_LO    = 4,
  parameter int GRP_W     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  scanStrb_t            strb,
  input  logic                 scanOn,
  input  logic                 runOn,
  input  logic [PER_W-1:0]     period,
  input  logic                 slowClk,
  input  logic                 wide32,
  input  logic                 gradEn,
  input  logic                 invGrp,
  input  logic                 grpNoOff,
  input  logic                 offGen,
  input  logic                 swapGrad,
  output logic                 slotEnd,
  output logic                 lastSlot,
  output logic [NUM_SLOTS-1:0] digitOut,
  output logic                 gradOut,
  output logic                 irq
);

  localparam int PW    = $clog2(DIV_SLOW);
  localparam int IDX_W = $clog2(NUM_SLOTS);

  logic [PW-1:0]    presc;
  logic [PW-1:0]    divLim;
  logic             tick;
  logic [PER_W-1:0] slotCnt;
  logic [IDX_W-1:0] slotIdx;
  logic [IDX_W-1:0] lastIdx;
  logic             offPhase;

  assign divLim   = slowClk ? PW'(DIV_SLOW - 1) : PW'(DIV_FAST - 1);
  assign tick     = runOn && (presc >= divLim);
  assign slotEnd  = tick && (slotCnt == '0);
  assign lastIdx  = (wide32 && !gradEn) ? IDX_W'(NUM_SLOTS - 1) : IDX_W'(NUM_SLOTS / 2 - 1);
  assign lastSlot = (slotIdx == lastIdx);
  assign offPhase = (slotCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc   <= '0;
      slotCnt <= '0;
      slotIdx <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= strb.irqFire;
      if (strb.restart || !runOn || tick) presc <= '0;
      else presc <= presc + 1'b1;
      if (strb.restart || strb.reload) slotCnt <= period;
      else if (tick) slotCnt <= slotCnt - 1'b1;
      if (strb.restart || strb.wrapIdx) slotIdx <= '0;
      else if (strb.stepIdx) slotIdx <= slotIdx + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_dig
    localparam logic IN_GRP = 1'((i >= GRP_LO) && (i < GRP_LO + GRP_W));
    logic litNow;
    assign litNow = scanOn && (slotIdx == IDX_W'(i))
                    && !(offPhase && offGen && !(grpNoOff && IN_GRP));
    assign digitOut[i] = litNow ^ (invGrp && IN_GRP);
  end

  assign gradOut = scanOn && gradEn && (swapGrad ? offPhase : !offPhase);

endmodule

// File: rtl/vfd_scan_timer.sv
module vfd_scan_timer
  import vfd_scan_pkg::*;
#(
  parameter int PER_W     = 8,
  parameter int NUM_SLOTS = 32,
  parameter int DIV_FAST  = 32,
  parameter int DIV_SLOW  = 128
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [1:0]           addr,
  input  logic [7:0]           wrData,
  output logic [7:0]           rdData,
  output logic [NUM_SLOTS-1:0] digitOut,
  output logic                 gradOut,
  output logic                 irq
);

  logic             autoEn, startBit, wide32, gradEn, slowClk;
  logic             invGrp, grpNoOff, offGen, swapGrad, startRise;
  logic [1:0]       scanCode;
  logic [PER_W-1:0] period;
  logic             slotEnd, lastSlot, scanOn, runOn;
  scanStrb_t        strb;

  vfd_scan_regs #(.PER_W(PER_W)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .autoEn(autoEn), .startBit(startBit), .scanCode(scanCode),
    .wide32(wide32), .gradEn(gradEn), .slowClk(slowClk), .invGrp(invGrp),
    .grpNoOff(grpNoOff), .offGen(offGen), .swapGrad(swapGrad),
    .period(period), .startRise(startRise)
  );

  vfd_scan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(autoEn && startBit), .startRise(startRise),
    .scanCode(scanCode), .slotEnd(slotEnd), .lastSlot(lastSlot),
    .strb(strb), .scanOn(scanOn), .runOn(runOn)
  );

  vfd_scan_dp #(
    .PER_W(PER_W), .NUM_SLOTS(NUM_SLOTS), .DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .scanOn(scanOn), .runOn(runOn),
    .period(period), .slowClk(slowClk), .wide32(wide32), .gradEn(gradEn),
    .invGrp(invGrp), .grpNoOff(grpNoOff), .offGen(offGen), .swapGrad(swapGrad),
    .slotEnd(slotEnd), .lastSlot(lastSlot), .digitOut(digitOut),
    .gradOut(gradOut), .irq(irq)
  );

endmodule

// File: rtl/vfd_scan_checker.sv
module vfd_scan_checker #(
  parameter int NUM_SLOTS = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 autoEn,
  input logic                 invGrp,
  input logic                 gradEn,
  input logic [1:0]           addr,
  input logic [7:0]           rdData,
  input logic [NUM_SLOTS-1:0] digitOut,
  input logic                 gradOut,
  input logic                 irq
);

  logic [NUM_SLOTS-1:0] invMask;
  assign invMask = invGrp ? NUM_SLOTS'(32'h0000_00F0) : '0;

  p_onehot_digits_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(digitOut ^ invMask))
    else $error("digit outputs not one-hot");

  p_idle_dark_r3: assert property (@(posedge clk) disable iff (!rstN)
    !autoEn |-> ((digitOut ^ invMask) == '0))
    else $error("digit active with auto-scan off");

  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq)
    else $error("irq longer than one cycle");

  p_grad_gate_r11: assert property (@(posedge clk) disable iff (!rstN)
    !gradEn |-> !gradOut)
    else $error("gradation output without gradation mode");

  p_mode_msb_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 2'd0) |-> !rdData[7])
    else $error("unassigned mode bit read as 1");

endmodule

bind vfd_scan_timer vfd_scan_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rstN(rstN), .autoEn(autoEn), .invGrp(invGrp), .gradEn(gradEn),
  .addr(addr), .rdData(rdData), .digitOut(digitOut), .gradOut(gradOut), .irq(irq)
);

// File: tb/sim_vfd_scan_timer.sv
module sim_vfd_scan_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  wrData = 8'd0;
  logic [7:0]  rdData;
  logic [31:0] digitOut;
  logic        gradOut;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int curM = 0;
  int irqCnt = 0;
  bit done = 0;

  vfd_scan_timer u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .digitOut(digitOut), .gradOut(gradOut), .irq(irq)
  );

  always #10 clk = ~clk;

  always @(negedge clk) if (rstN && irq) irqCnt++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    #1 irqCnt = 0;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    curM = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic gotoM(input int m);
    while (curM < m) begin
      @(negedge clk);
      curM++;
    end
    #1;
  endtask

  task automatic startScan(input logic [7:0] mode);
    wr(2'd0, mode & 8'hFD);
    wr(2'd0, mode | 8'h02);
  endtask

  initial begin
    logic [7:0] r;
    repeat (5) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), r);
      check("R1 reg reset", {24'd0, r}, 32'd0);
    end
    check("R1 digits", digitOut, 32'd0);
    check("R1 irq/grad", {30'd0, irq, gradOut}, 32'd0);
    rstN = 1'b1;

    // R2 register map, unassigned bits
    wr(2'd0, 8'hFF); rd(2'd0, r); check("R2 mode readback", {24'd0, r}, 32'h7F);
    wr(2'd1, 8'hFF); rd(2'd1, r); check("R2 ctrl readback", {24'd0, r}, 32'hA5);
    wr(2'd2, 8'hFF); rd(2'd2, r); check("R2 period readback", {24'd0, r}, 32'hFF);
    wr(2'd3, 8'hFF); rd(2'd3, r); check("R2 addr3 reads 0", {24'd0, r}, 32'h0);
    rd(2'd2, r); check("R2 addr3 write no effect", {24'd0, r}, 32'hFF);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);

    // R3 start without auto-scan
    wr(2'd0, 8'h02);
    gotoM(100); check("R3 idle dark", digitOut, 32'd0);
    wr(2'd0, 8'h00);

    // R4 / R8 slot sweep with code 0
    for (int n = 0; n < 4; n += (n == 1) ? 2 : 1) begin
      int s;
      s = (n + 1) * 32;
      wr(2'd2, 8'(n));
      startScan(8'h01);
      for (int k = 0; k < 16; k++) begin
        gotoM(k * s + s / 2);
        check("R4 digit sweep", digitOut, 32'd1 << k);
      end
      gotoM(16 * s - 1);
      check("R8 irq per slot", irqCnt, 32'd16);
      gotoM(16 * s + s / 2);
      check("R4 wrap to digit 0", digitOut, 32'd1);
    end
    wr(2'd0, 8'h01);
    gotoM(3); check("R4 stop darkens", digitOut, 32'd0);

    // R5 slow divider
    wr(2'd2, 8'd0);
    startScan(8'h41);
    gotoM(127); check("R5 slow slot0 end", digitOut, 32'd1);
    gotoM(192); check("R5 slow slot1", digitOut, 32'd2);

    // R6 frame length
    startScan(8'h11);
    gotoM(20 * 32 + 16); check("R6 slot 20", digitOut, 32'd1 << 20);
    gotoM(31 * 32 + 16); check("R6 slot 31", digitOut, 32'h8000_0000);
    gotoM(32 * 32 + 16); check("R6 32-frame wrap", digitOut, 32'd1);
    startScan(8'h31);
    gotoM(16 * 32 + 16); check("R6 gradation limits to 16", digitOut, 32'd1);

    // R7 / R8 blanking codes
    for (int c = 1; c < 4; c++) begin
      startScan(8'h01 | 8'(c << 2));
      gotoM(15 * 32 + 16); check("R7 last slot", digitOut, 32'h8000);
      gotoM(16 * 32 + 16); check("R7 blank start", digitOut, 32'd0);
      gotoM((16 + c) * 32 - 1); check("R7 blank end", digitOut, 32'd0);
      gotoM((16 + c) * 32 + 16); check("R7 restart digit 0", digitOut, 32'd1);
      gotoM(2 * (16 + c) * 32 - 1); check("R8 one irq per frame", irqCnt, 32'd2);
    end

    // R9 group inversion
    wr(2'd1, 8'h01); wr(2'd0, 8'h00);
    check("R9 idle inverted group", digitOut, 32'hF0);
    startScan(8'h01);
    gotoM(16); check("R9 slot0 inverted", digitOut, 32'hF1);
    gotoM(5 * 32 + 16); check("R9 slot5 inverted", digitOut, 32'hD0);

    // R10 off phase
    wr(2'd2, 8'd1);
    wr(2'd1, 8'h20);
    startScan(8'h01);
    gotoM(10); check("R10 on phase", digitOut, 32'd1);
    gotoM(40); check("R10 off phase", digitOut, 32'd0);
    gotoM(5 * 64 + 40); check("R10 group off", digitOut, 32'd0);
    wr(2'd1, 8'h24);
    startScan(8'h01);
    gotoM(5 * 64 + 40); check("R10 group exempt", digitOut, 32'h20);
    gotoM(8 * 64 + 40); check("R10 non-group off", digitOut, 32'd0);

    // R11 gradation
    wr(2'd1, 8'h00);
    startScan(8'h21);
    gotoM(10); check("R11 set first", {31'd0, gradOut}, 32'd1);
    gotoM(40); check("R11 clear at off", {31'd0, gradOut}, 32'd0);
    wr(2'd1, 8'h80);
    startScan(8'h21);
    gotoM(10); check("R11 swap clear first", {31'd0, gradOut}, 32'd0);
    gotoM(40); check("R11 swap set at off", {31'd0, gradOut}, 32'd1);
    startScan(8'h01);
    gotoM(10); check("R11 disabled", {31'd0, gradOut}, 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule